// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Address Path

This block sits between a peripheral that moves data in 16-bit units and a memory port. It accepts one request at a time. A request carries an address, a length in bytes, a direction and a bypass flag. The block ORs a base value into the request address and issues memory commands. Data moves one halfword per cycle, with valid/ready handshakes on both sides.

In normal (swap) mode the block clears the low bit of both the address and the length. It exchanges the two bytes of every halfword, in both directions. A memory write is cut into consecutive bursts of at most `MAX_BURST` bytes, and the address advances by each burst's length. In bypass mode the address and length pass through unaltered and the data is not swapped.

A single-cycle done pulse marks the end of every request. A request whose effective length is zero finishes at once, without touching memory.

Top module: `halfswap_dma`

## Requirements
- R1: Every command address is `req_addr | base_addr`; in swap mode (`req_bypass`=0) its bit 0 is then cleared, in bypass mode it is left as is.
- R2: In swap mode the effective byte length is `req_len` with bit 0 cleared; in bypass mode it is `req_len` unchanged.
- R3: In bypass mode a transfer is one command of the full length, and every halfword passes unmodified in either direction.
- R4: In swap mode each data halfword leaves as `{d[7:0], d[15:8]}` for input `d`, on the write path (`in_data`→`mem_wdata`) and the read path (`mem_rdata`→`out_data`).
- R5: A swap-mode write (`req_write`=1) is issued as consecutive commands of `MAX_BURST` (64) bytes, followed by a final shorter one if bytes remain. Each command's address is the previous one plus its length. A command holds its address and length while `mem_cmd_ready` is low.
- R6: A swap-mode read is one command of the effective length. Each command is followed by exactly ceil(len/2) data beats, one per handshake, before the next command.
- R7: `done` is high for exactly one cycle per request, in the cycle after the final data beat is accepted.
- R8: A request whose effective length is zero raises `done` in the cycle after acceptance and issues no memory command.
- R9: `req_ready` is high only while no request is in progress; during a transfer no new request is taken.
- R10: After reset, `req_ready`=1 and `done`, `mem_cmd_valid`, `mem_wvalid` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | AW | Base value ORed into every address |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted on valid |
| req_addr | input | AW | Request byte address |
| req_len | input | LW | Request byte length |
| req_write | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| req_bypass | input | 1 | 1: no swap, no alignment, no burst split |
| in_valid | input | 1 | Write halfword from peripheral valid |
| in_ready | output | 1 | Write halfword taken |
| in_data | input | 16 | Write halfword from peripheral |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory command accepted |
| mem_cmd_addr | output | AW | Memory command byte address |
| mem_cmd_len | output | LW | Memory command byte length |
| mem_cmd_write | output | 1 | Memory command direction |
| mem_wvalid | output | 1 | Memory write halfword valid |
| mem_wready | input | 1 | Memory write halfword taken |
| mem_wdata | output | 16 | Memory write halfword |
| mem_rvalid | input | 1 | Memory read halfword valid |
| mem_rready | output | 1 | Memory read halfword taken |
| mem_rdata | input | 16 | Memory read halfword |
| out_valid | output | 1 | Read halfword to peripheral valid |
| out_ready | input | 1 | Peripheral takes read halfword |
| out_data | output | 16 | Read halfword to peripheral |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a swap-mode write whose burst boundaries fall while both the command and the write-data channels are being stalled. The burst-to-burst switch must then resume with the correct next address and without losing or repeating a halfword. The stimulus uses lengths of 2, 64, 66, 130 and an odd 131 bytes. It combines them with odd addresses and non-zero base values, while `mem_cmd_ready`, `mem_wready` and `out_ready` are withheld on different repeating cycle patterns. Each command and each halfword is compared in the order produced.

// File: rtl/halfswap_dma.sv
module halfswap_dma #(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int MAX_BURST = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_write,
  input  logic          req_bypass,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [15:0]   in_data,
  output logic          mem_cmd_valid,
  input  logic          mem_cmd_ready,
  output logic [AW-1:0] mem_cmd_addr,
  output logic [LW-1:0] mem_cmd_len,
  output logic          mem_cmd_write,
  output logic          mem_wvalid,
  input  logic          mem_wready,
  output logic [15:0]   mem_wdata,
  input  logic          mem_rvalid,
  output logic          mem_rready,
  input  logic [15:0]   mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [15:0]   out_data,
  output logic          done
);

  localparam logic [LW-1:0] BURST = LW'(MAX_BURST);

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_DATA, S_DONE} state_t;

  state_t        state;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;
  logic [LW-1:0] beats_q;
  logic          bypass_q;
  logic          write_q;

  logic [AW-1:0] joined_addr;
  logic [AW-1:0] start_addr;
  logic [LW-1:0] start_len;
  logic [LW-1:0] cur_len;
  logic [LW:0]   cur_len_up;
  logic          in_data_phase;
  logic          beat;

  assign joined_addr = req_addr | base_addr;
  assign start_addr  = req_bypass ? joined_addr : {joined_addr[AW-1:1], 1'b0};
  assign start_len   = req_bypass ? req_len : {req_len[LW-1:1], 1'b0};

  assign cur_len    = (write_q && !bypass_q && rem_q > BURST) ? BURST : rem_q;
  assign cur_len_up = {1'b0, cur_len} + 1'b1;

  assign req_ready     = (state == S_IDLE);
  assign done          = (state == S_DONE);
  assign in_data_phase = (state == S_DATA);

  assign mem_cmd_valid = (state == S_CMD);
  assign mem_cmd_addr  = addr_q;
  assign mem_cmd_len   = cur_len;
  assign mem_cmd_write = write_q;

  assign mem_wvalid = in_data_phase && write_q && in_valid;
  assign in_ready   = in_data_phase && write_q && mem_wready;
  assign mem_wdata  = bypass_q ? in_data : {in_data[7:0], in_data[15:8]};

  assign out_valid  = in_data_phase && !write_q && mem_rvalid;
  assign mem_rready = in_data_phase && !write_q && out_ready;
  assign out_data   = bypass_q ? mem_rdata : {mem_rdata[7:0], mem_rdata[15:8]};

  assign beat = write_q ? (mem_wvalid && mem_wready) : (out_valid && out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      rem_q    <= '0;
      beats_q  <= '0;
      bypass_q <= 1'b0;
      write_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q   <= start_addr;
          rem_q    <= start_len;
          bypass_q <= req_bypass;
          write_q  <= req_write;
          state    <= (start_len == '0) ? S_DONE : S_CMD;
        end
        S_CMD: if (mem_cmd_ready) begin
          addr_q  <= addr_q + AW'(cur_len);
          rem_q   <= rem_q - cur_len;
          beats_q <= cur_len_up[LW:1];
          state   <= S_DATA;
        end
        S_DATA: if (beat) begin
          beats_q <= beats_q - 1'b1;
          if (beats_q == LW'(1))
            state <= (rem_q == '0) ? S_DONE : S_CMD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && mem_cmd_write && !bypass_q) |-> (mem_cmd_len <= BURST && mem_cmd_len != '0));

  // R1 R2
  swap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !bypass_q) |-> (!mem_cmd_addr[0] && !mem_cmd_len[0]));

  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=> (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_len)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_cmd_valid && !mem_wvalid && !out_valid && !done));

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len[LW-1:1] == '0 && (!req_len[0] || !req_bypass)) |=> (done && !mem_cmd_valid));

endmodule

// File: tb/halfswap_dma_bench.sv
module halfswap_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_addr = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        req_write = 1'b0, req_bypass = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [15:0] in_data = '0;
  logic        mem_cmd_valid, mem_cmd_ready = 1'b0;
  logic [31:0] mem_cmd_addr;
  logic [15:0] mem_cmd_len;
  logic        mem_cmd_write;
  logic        mem_wvalid, mem_wready = 1'b0;
  logic [15:0] mem_wdata;
  logic        mem_rvalid = 1'b0, mem_rready;
  logic [15:0] mem_rdata = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [15:0] out_data;
  logic        done;

  halfswap_dma u_halfswap_dma (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, done_cnt = 0, cyc = 0;
  logic [48:0] cmd_q[$];
  logic [15:0] wd_q[$];
  logic [15:0] rd_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sw(input logic [15:0] d);
    return {d[7:0], d[15:8]};
  endfunction

  always @(negedge clk) begin
    cyc++;
    mem_cmd_ready <= (cyc % 3) != 0;
    mem_wready    <= (cyc % 4) != 1;
    out_ready     <= (cyc % 5) != 2;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (done) done_cnt++;
      if (mem_cmd_valid && mem_cmd_ready) begin
        if (cmd_q.size() == 0) chk(0, "R8 unexpected command", {15'b0, mem_cmd_write, mem_cmd_len, mem_cmd_addr}, 0);
        else begin
          logic [48:0] e;
          e = cmd_q.pop_front();
          // R1 R2 R3 R5 R6
          chk({mem_cmd_write, mem_cmd_len, mem_cmd_addr} == e, "R1/R2/R5 command",
              {15'b0, mem_cmd_write, mem_cmd_len, mem_cmd_addr}, {15'b0, e});
        end
      end
      if (mem_wvalid && mem_wready) begin
        if (wd_q.size() == 0) chk(0, "R6 extra write beat", 64'(mem_wdata), 0);
        else begin
          logic [15:0] e;
          e = wd_q.pop_front();
          chk(mem_wdata == e, "R3/R4 write data", 64'(mem_wdata), 64'(e));
        end
      end
      if (out_valid && out_ready) begin
        if (rd_q.size() == 0) chk(0, "R6 extra read beat", 64'(out_data), 0);
        else begin
          logic [15:0] e;
          e = rd_q.pop_front();
          chk(out_data == e, "R3/R4 read data", 64'(out_data), 64'(e));
        end
      end
    end
  end

  task automatic push_cmds(input logic [31:0] a, input int len, input bit byp, input bit wr, output int nb);
    logic [31:0] ea;
    int el;
    ea = a | base_addr;
    el = len;
    if (!byp) begin ea[0] = 1'b0; el = len & ~1; end
    nb = 0;
    if (byp || !wr) begin
      if (el > 0) cmd_q.push_back({wr, 16'(el), ea});
      nb = (el + 1) / 2;
    end else begin
      while (el > 0) begin
        int c;
        c = (el > 64) ? 64 : el;
        cmd_q.push_back({wr, 16'(c), ea});
        nb += c / 2;
        ea += 32'(c);
        el -= c;
      end
    end
  endtask

  task automatic issue_req(input logic [31:0] a, input int len, input bit byp, input bit wr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = 16'(len); req_bypass = byp; req_write = wr;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int prev, input string tag);
    int t = 0;
    while (done_cnt == prev && t < 400) begin @(negedge clk); #3; t++; end
    // R7
    chk(done_cnt == prev + 1, tag, 64'(done_cnt), 64'(prev + 1));
    chk(cmd_q.size() == 0 && wd_q.size() == 0 && rd_q.size() == 0, "R6 R7 all items seen before done",
        64'(cmd_q.size() + wd_q.size() + rd_q.size()), 0);
    repeat (3) @(negedge clk);
    #3;
    chk(done_cnt == prev + 1, "R7 single done pulse", 64'(done_cnt), 64'(prev + 1));
  endtask

  task automatic do_write(input logic [31:0] a, input int len, input bit byp, input logic [15:0] seed);
    int nb, k, prev;
    bit seen;
    prev = done_cnt;
    push_cmds(a, len, byp, 1'b1, nb);
    for (int i = 0; i < nb; i++) wd_q.push_back(byp ? 16'(seed + i) : sw(16'(seed + i)));
    issue_req(a, len, byp, 1'b1);
    k = 0; seen = 0;
    while (k < nb) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 16'(seed + k);
      #1;
      if (!seen) begin
        seen = 1;
        chk(req_ready == 1'b0, "R9 busy during transfer", 64'(req_ready), 0);
      end
      if (in_ready) k++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    wait_done(prev, "R7 write done");
  endtask

  task automatic do_read(input logic [31:0] a, input int len, input bit byp, input logic [15:0] seed);
    int nb, k, prev;
    prev = done_cnt;
    push_cmds(a, len, byp, 1'b0, nb);
    for (int i = 0; i < nb; i++) rd_q.push_back(byp ? 16'(seed + i) : sw(16'(seed + i)));
    issue_req(a, len, byp, 1'b0);
    k = 0;
    while (k < nb) begin
      @(negedge clk);
      mem_rvalid = 1'b1; mem_rdata = 16'(seed + k);
      #1;
      if (mem_rready) k++;
    end
    @(negedge clk);
    mem_rvalid = 1'b0;
    wait_done(prev, "R7 read done");
  endtask

  task automatic do_zero(input logic [31:0] a, input int len, input bit byp, input bit wr);
    int prev;
    prev = done_cnt;
    issue_req(a, len, byp, wr);
    @(negedge clk); #3;
    // R8
    chk(done_cnt == prev + 1, "R8 zero-length immediate done", 64'(done_cnt), 64'(prev + 1));
    repeat (3) @(negedge clk);
    #3;
    chk(done_cnt == prev + 1 && req_ready, "R8 no further activity", 64'(done_cnt), 64'(prev + 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #3;
    // R10
    chk(req_ready == 1'b1, "R10 req_ready after reset", 64'(req_ready), 1);
    chk(!done && !mem_cmd_valid && !mem_wvalid && !out_valid, "R10 outputs idle after reset",
        {60'b0, done, mem_cmd_valid, mem_wvalid, out_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 burst boundaries
    do_write(32'h0000_0100, 2, 1'b0, 16'h1200);
    do_write(32'h0000_0201, 64, 1'b0, 16'h3400);
    base_addr = 32'h8000_0000;
    do_write(32'h0000_1000, 66, 1'b0, 16'h5600);
    base_addr = 32'h0000_0010;
    do_write(32'h0000_0003, 130, 1'b0, 16'h7800);
    do_write(32'h0000_0003, 131, 1'b0, 16'h9A00);
    // R3 bypass writes: no alignment, no split, no swap
    do_write(32'h0000_0005, 5, 1'b1, 16'hBC01);
    do_write(32'h0000_0400, 200, 1'b1, 16'hC100);
    // R4 R6 reads
    base_addr = 32'h0;
    do_read(32'h0000_0041, 9, 1'b0, 16'hA1B2);
    do_read(32'h0000_0800, 130, 1'b0, 16'h0102);
    // R3 bypass read
    do_read(32'h0000_0007, 3, 1'b1, 16'hDE00);
    // R8 zero effective length
    do_zero(32'h0000_0007, 1, 1'b0, 1'b1);
    do_zero(32'h0000_0010, 0, 1'b0, 1'b0);
    do_zero(32'h0000_0011, 0, 1'b1, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule